// File: doc/BRIEF.md
# Numeric Digit Move Execution Unit

This block executes one instruction of a character-oriented decimal machine: copy the four numeric bits of a source character into a destination character. The zone bits, the word mark and the check bit of the destination stay as they were. The source is only read, never written. The instruction fetch unit passes in the instruction length, the A and B addresses and a one-cycle start strobe. The unit then runs a short sequence of memory cycles against a single-port character memory. That memory returns read data one clock after it receives an address.

Before any memory access the unit checks three things, in this order: the instruction length, then the A address, then the B address. A failure in any of them ends the instruction with an error pulse and a code.

Three instruction forms are supported:
- The two-address form uses both addresses.
- The one-address form uses the A address as both source and destination.
- The chained form uses the address values left in the unit's own registers by the previous instruction.

There are also two timing modes. The step mode takes the memory cycles one at a time and moves the A register down first. The fast mode overlaps the first read with the start cycle and moves both registers down together at the end.

Top module: `numdig_move_unit`

## Requirements
- R1: The stored character is the destination's bits 7:4 (check bit 7, word mark 6, zones 5:4) followed by the source's bits 3:0 (numeric 8,4,2,1). No other memory location changes.
- R2: Only length codes 1 (chained), 4 (one-address) and 7 (two-address) are accepted. Any other length gives err_o with code 1 and no memory write. Length is checked before the addresses.
- R3: An address is valid when it is below MEM_SIZE. An invalid A gives code 2. If A is valid, an invalid B gives code 3. A is judged before B.
- R4: On any error, no write takes place and both address outputs keep their previous values.
- R5: Each accepted instruction makes exactly one write and then raises done_o for one cycle. In step mode, done_o is high in the 4th cycle after the start cycle. In fast mode, it is high in the 3rd cycle.
- R6: In step mode, the A output has already dropped by one in the 2nd cycle after start, while B is unchanged. In fast mode, both still hold their starting values in that cycle.
- R7: After completion, the A and B outputs each hold their starting value minus 1, modulo 2^ADDR_W.
- R8: In the one-address form, B is loaded from A. The character at A therefore keeps its value, and both outputs end at A minus 1.
- R9: The chained form ignores the address inputs and uses the currently held A and B values. This includes a start given in the same cycle as the previous done_o.
- R10: start_i is ignored while an instruction is in progress.
- R11: err_o is a one-cycle pulse in the cycle after start. done_o and err_o are never high together. err_code_o is 0 with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for one instruction |
| fast_i | input | 1 | 1 selects the fast timing mode |
| len_i | input | 3 | Instruction length code |
| a_addr_i | input | ADDR_W | Source address for forms 4 and 7 |
| b_addr_i | input | ADDR_W | Destination address for form 7 |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Error pulse |
| err_code_o | output | 3 | 1 length, 2 A address, 3 B address, 4 microstate decode |
| a_addr_o | output | ADDR_W | Held A register |
| b_addr_o | output | ADDR_W | Held B register |

## Verification
The completion of one instruction and the acceptance of the next can fall in the same cycle. The bench issues every instruction at the sample point where the previous done_o is seen, so a chained start coincides with the done pulse and must pick up the registers just decremented. It judges this by deriving the effective addresses from its own register model. When those addresses wrapped below zero, it expects the address error code. A second overlap is the write to the destination in the cycle after its read. In the one-address form both land on the same location, and the bench checks that the character comes back unchanged.

// File: rtl/numdig_pkg.sv
package numdig_pkg;

    localparam int CHAR_W  = 8;
    localparam int NUM_W   = 4;
    localparam int LEN_W   = 3;
    localparam int CODE_W  = 3;

    localparam logic [LEN_W-1:0] LEN_CHAIN = 3'd1;
    localparam logic [LEN_W-1:0] LEN_ONE   = 3'd4;
    localparam logic [LEN_W-1:0] LEN_TWO   = 3'd7;

    localparam logic [CODE_W-1:0] ERR_NONE   = 3'd0;
    localparam logic [CODE_W-1:0] ERR_LEN    = 3'd1;
    localparam logic [CODE_W-1:0] ERR_A      = 3'd2;
    localparam logic [CODE_W-1:0] ERR_B      = 3'd3;
    localparam logic [CODE_W-1:0] ERR_DECODE = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_A   = 3'd1,
        ST_RD_B   = 3'd2,
        ST_WR_B   = 3'd3,
        ST_F_RD_B = 3'd4,
        ST_F_WR   = 3'd5
    } mv_state_e;

endpackage

// File: rtl/numdig_validate.sv
module numdig_validate #(
    parameter int MEM_SIZE = 16000,
    parameter int ADDR_W   = $clog2(MEM_SIZE)
) (
    input  logic [numdig_pkg::LEN_W-1:0]  len_i,
    input  logic [ADDR_W-1:0]             a_i,
    input  logic [ADDR_W-1:0]             b_i,
    output logic [numdig_pkg::CODE_W-1:0] code_o
);
    import numdig_pkg::*;

    localparam logic [ADDR_W:0] LIMIT = MEM_SIZE[ADDR_W:0];

    logic len_ok;
    logic a_ok;
    logic b_ok;

    always_comb begin
        len_ok = (len_i == LEN_CHAIN) || (len_i == LEN_ONE) || (len_i == LEN_TWO);
        a_ok   = {1'b0, a_i} < LIMIT;
        b_ok   = {1'b0, b_i} < LIMIT;
        if (!len_ok)      code_o = ERR_LEN;
        else if (!a_ok)   code_o = ERR_A;
        else if (!b_ok)   code_o = ERR_B;
        else              code_o = ERR_NONE;
    end

    always_comb begin
        if (code_o == ERR_B) begin
            AST_B_AFTER_A: assert (a_ok && len_ok); // R3
        end
    end

endmodule

// File: rtl/numdig_merge.sv
module numdig_merge (
    input  logic [numdig_pkg::CHAR_W-1:0] dst_i,
    input  logic [numdig_pkg::CHAR_W-1:0] src_i,
    output logic [numdig_pkg::CHAR_W-1:0] out_o
);
    import numdig_pkg::*;

    for (genvar g = 0; g < CHAR_W; g++) begin : g_bit
        if (g < NUM_W) begin : g_num
            assign out_o[g] = src_i[g];
        end else begin : g_keep
            assign out_o[g] = dst_i[g];
        end
    end

endmodule

// File: rtl/numdig_move_unit.sv
module numdig_move_unit #(
    parameter int MEM_SIZE = 16000,
    parameter int ADDR_W   = $clog2(MEM_SIZE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              fast_i,
    input  logic [2:0]        len_i,
    input  logic [ADDR_W-1:0] a_addr_i,
    input  logic [ADDR_W-1:0] b_addr_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_rdata_i,
    output logic [7:0]        mem_wdata_o,
    output logic              mem_we_o,
    output logic              done_o,
    output logic              err_o,
    output logic [2:0]        err_code_o,
    output logic [ADDR_W-1:0] a_addr_o,
    output logic [ADDR_W-1:0] b_addr_o
);
    import numdig_pkg::*;

    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        mv_state_e         st;
        logic [ADDR_W-1:0] a;
        logic [ADDR_W-1:0] b;
        logic [CHAR_W-1:0] src;
        logic              done;
        logic              err;
        logic [CODE_W-1:0] code;
    } regs_t;

    regs_t r_q, r_d;

    logic [ADDR_W-1:0] a_eff_d;
    logic [ADDR_W-1:0] b_eff_d;
    logic [CODE_W-1:0] chk_code;
    logic [CHAR_W-1:0] merged;

    // effective operands for the three instruction forms
    always_comb begin
        case (len_i)
            LEN_CHAIN: begin a_eff_d = r_q.a;    b_eff_d = r_q.b;    end
            LEN_ONE:   begin a_eff_d = a_addr_i; b_eff_d = a_addr_i; end
            default:   begin a_eff_d = a_addr_i; b_eff_d = b_addr_i; end
        endcase
    end

    numdig_validate #(.MEM_SIZE(MEM_SIZE), .ADDR_W(ADDR_W)) u_validate (
        .len_i  (len_i),
        .a_i    (a_eff_d),
        .b_i    (b_eff_d),
        .code_o (chk_code)
    );

    numdig_merge u_merge (
        .dst_i (mem_rdata_i),
        .src_i (r_q.src),
        .out_o (merged)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        r_d.code = ERR_NONE;
        mem_addr_o = r_q.b;
        mem_we_o   = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                mem_addr_o = a_eff_d;
                if (start_i) begin
                    if (chk_code != ERR_NONE) begin
                        r_d.err  = 1'b1;
                        r_d.code = chk_code;
                    end else begin
                        r_d.a  = a_eff_d;
                        r_d.b  = b_eff_d;
                        r_d.st = fast_i ? ST_F_RD_B : ST_RD_A;
                    end
                end
            end
            ST_RD_A: begin
                mem_addr_o = r_q.a;
                r_d.a      = r_q.a - ONE;
                r_d.st     = ST_RD_B;
            end
            ST_RD_B: begin
                mem_addr_o = r_q.b;
                r_d.src    = mem_rdata_i;
                r_d.st     = ST_WR_B;
            end
            ST_WR_B: begin
                mem_addr_o = r_q.b;
                mem_we_o   = 1'b1;
                r_d.b      = r_q.b - ONE;
                r_d.done   = 1'b1;
                r_d.st     = ST_IDLE;
            end
            ST_F_RD_B: begin
                mem_addr_o = r_q.b;
                r_d.src    = mem_rdata_i;
                r_d.st     = ST_F_WR;
            end
            ST_F_WR: begin
                mem_addr_o = r_q.b;
                mem_we_o   = 1'b1;
                r_d.a      = r_q.a - ONE;
                r_d.b      = r_q.b - ONE;
                r_d.done   = 1'b1;
                r_d.st     = ST_IDLE;
            end
            default: begin
                r_d.err  = 1'b1;
                r_d.code = ERR_DECODE;
                r_d.st   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_wdata_o = merged;
    assign done_o      = r_q.done;
    assign err_o       = r_q.err;
    assign err_code_o  = r_q.code;
    assign a_addr_o    = r_q.a;
    assign b_addr_o    = r_q.b;

    AST_WRITE_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> done_o); // R5
    AST_ZONES_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> mem_wdata_o[7:4] == mem_rdata_i[7:4]); // R1
    AST_ERR_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(a_addr_o) && $stable(b_addr_o))); // R4
    AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> err_code_o != ERR_NONE); // R3
    AST_DONE_ERR_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R11
    AST_B_STEPPED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> b_addr_o == $past(b_addr_o) - ONE); // R7

endmodule

// File: tb/numdig_move_unit_tb.sv
`timescale 1ns/1ps
module numdig_move_unit_tb;
    localparam int MS = 40;
    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic fast_i = 1'b0;
    logic [2:0] len_i = 3'd0;
    logic [AW-1:0] a_addr_i = '0;
    logic [AW-1:0] b_addr_i = '0;
    logic [AW-1:0] mem_addr_o;
    logic [7:0] mem_rdata_i;
    logic [7:0] mem_wdata_o;
    logic mem_we_o, done_o, err_o;
    logic [2:0] err_code_o;
    logic [AW-1:0] a_addr_o, b_addr_o;

    int checks = 0;
    int errors = 0;
    logic [AW-1:0] ha = '0;
    logic [AW-1:0] hb = '0;
    logic [7:0] mem [64];

    always #2 clk = ~clk;

    numdig_move_unit #(.MEM_SIZE(MS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .fast_i(fast_i),
        .len_i(len_i), .a_addr_i(a_addr_i), .b_addr_i(b_addr_i),
        .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
        .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
        .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o),
        .a_addr_o(a_addr_o), .b_addr_o(b_addr_o)
    );

    always @(posedge clk) begin
        if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
        mem_rdata_i <= mem[mem_addr_o];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [2:0] len, input logic [AW-1:0] a,
                       input logic [AW-1:0] b, input logic fast, input bit poke);
        logic [AW-1:0] ea, eb, ma, mb, xa;
        logic [2:0] ecode, gcode;
        logic [7:0] snap [64];
        logic [7:0] expm [64];
        int n, wecnt, diffs;
        bit got;
        logic gdone, gerr;
        if (len == 3'd1)      begin ea = ha; eb = hb; end
        else if (len == 3'd4) begin ea = a;  eb = a;  end
        else                  begin ea = a;  eb = b;  end
        if (len != 3'd1 && len != 3'd4 && len != 3'd7) ecode = 3'd1;
        else if (int'(ea) >= MS)                        ecode = 3'd2;
        else if (int'(eb) >= MS)                        ecode = 3'd3;
        else                                            ecode = 3'd0;
        for (int i = 0; i < 64; i++) begin snap[i] = mem[i]; expm[i] = mem[i]; end
        if (ecode == 3'd0) expm[eb] = {snap[eb][7:4], snap[ea][3:0]};
        start_i = 1'b1; len_i = len; a_addr_i = a; b_addr_i = b; fast_i = fast;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        n = 0; got = 0; wecnt = 0; ma = '0; mb = '0;
        gdone = 0; gerr = 0; gcode = '0;
        while (!got && n < 20) begin
            n++;
            if (n == 3) start_i = 1'b0;
            if (mem_we_o) wecnt++;
            if (n == 2) begin
                ma = a_addr_o; mb = b_addr_o;
                if (poke) begin
                    start_i = 1'b1; len_i = 3'd7; fast_i = ~fast;
                    a_addr_i = a ^ 6'd5; b_addr_i = b ^ 6'd3;
                end
            end
            if (done_o || err_o) begin
                got = 1; gdone = done_o; gerr = err_o; gcode = err_code_o;
            end else begin
                @(negedge clk);
            end
        end
        chk(got, "R5", "response seen", got, 1);
        diffs = 0;
        for (int i = 0; i < 64; i++) if (mem[i] !== expm[i]) diffs++;
        chk(diffs == 0, "R1", "memory image mismatches", diffs, 0);
        if (ecode != 3'd0) begin
            chk(gerr && !gdone, (ecode == 3'd1) ? "R2" : "R3", "error pulse", gerr, 1);
            chk(gcode == ecode, (ecode == 3'd1) ? "R2" : "R3", "error code", gcode, ecode);
            chk(n == 1, "R11", "error cycle", n, 1);
            chk(wecnt == 0, "R4", "writes on error", wecnt, 0);
            chk(a_addr_o == ha, "R4", "A kept", a_addr_o, ha);
            chk(b_addr_o == hb, "R4", "B kept", b_addr_o, hb);
        end else begin
            chk(gdone && !gerr, "R11", "done without error", gdone, 1);
            chk(gcode == 3'd0, "R11", "code with done", gcode, 0);
            chk(n == (fast ? 3 : 4), "R5", "done cycle", n, fast ? 3 : 4);
            chk(wecnt == 1, "R5", "write count", wecnt, 1);
            xa = fast ? ea : ea - 6'd1;
            chk(ma == xa, "R6", "A mid-sequence", ma, xa);
            chk(mb == eb, "R6", "B mid-sequence", mb, eb);
            if (ea != eb)
                chk(mem[ea] == snap[ea], "R1", "source untouched", mem[ea], snap[ea]);
            ha = ea - 6'd1; hb = eb - 6'd1;
            chk(a_addr_o == ha, "R7", "final A", a_addr_o, ha);
            chk(b_addr_o == hb, "R7", "final B", b_addr_o, hb);
            if (len == 3'd4) begin
                chk(b_addr_o == a - 6'd1, "R8", "one-address B", b_addr_o, a - 6'd1);
                chk(mem[a] == snap[a], "R8", "self move unchanged", mem[a], snap[a]);
            end
            if (len == 3'd1)
                chk(diffs == 0, "R9", "chained image", diffs, 0);
            if (poke)
                chk(diffs == 0 && n == (fast ? 3 : 4), "R10", "busy start ignored", diffs, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 11);
        repeat (3) @(negedge clk);
        chk(!done_o && !err_o && !mem_we_o, "R11", "reset outputs quiet", done_o, 0);
        chk(a_addr_o == 0 && b_addr_o == 0, "R7", "reset registers", a_addr_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int f = 0; f < 2; f++) begin
            for (int a = 0; a < MS; a++) begin
                run(3'd7, 6'(a), 6'((a * 7 + 3) % MS), f[0], 1'b0);
                if (a % 4 == 0) run(3'd1, 6'd0, 6'd0, ~f[0], 1'b0);
                if (a % 6 == 1) run(3'd4, 6'((a * 3) % MS), 6'd50, f[0], 1'b0);
                if (a % 9 == 2) run(3'd7, 6'((a + 11) % MS), 6'(a), f[0], 1'b1);
            end
        end
        for (int l = 0; l < 8; l++) run(3'(l), 6'd5, 6'd6, 1'b0, 1'b0);
        run(3'd2, 6'd50, 6'd60, 1'b0, 1'b0);
        run(3'd7, 6'd45, 6'd50, 1'b1, 1'b0);
        run(3'd7, 6'd10, 6'd50, 1'b0, 1'b0);
        run(3'd4, 6'd63, 6'd1, 1'b0, 1'b0);
        run(3'd7, 6'd0, 6'd5, 1'b0, 1'b0);
        run(3'd1, 6'd20, 6'd20, 1'b1, 1'b0);
        run(3'd7, 6'd8, 6'd0, 1'b1, 1'b0);
        run(3'd1, 6'd1, 6'd1, 1'b0, 1'b0);
        run(3'd7, 6'd39, 6'd39, 1'b0, 1'b0);
        run(3'd1, 6'd0, 6'd0, 1'b1, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule